// File: doc/BRIEF.md
# Nested Two-Level Transfer Counter

This block is the count engine of a descriptor-driven DMA channel. It is loaded with one counter word that carries three fields. The low byte holds the inner-loop start value. The next byte holds the inner-loop remaining count. The upper half holds the outer-loop remaining count. Every accepted step strobe uses up one transfer. The inner count runs down to 1. It is then restored from the start value while the outer count drops by one. The step taken with both counts at 1 is the final transfer, and a one-cycle strobe marks it.

Both loop sizes use a zero-means-maximum encoding. A successful run leaves a residue of 1 in each count rather than 0. When reload is enabled, the counter word is instead replaced by a second word after the final transfer. A descriptor whose inner remaining count exceeds its start value is refused at load time. An error strobe stops the sequence and leaves the counts as they stood before the failing step. The word presented on the output is the value to be written back to the descriptor.

Top module: `nested_xfer_counter`

## Requirements
- R1: On load, bits 7:0 of the input word become the inner start field, bits 15:8 the inner remaining field and bits 31:16 the outer remaining field. The output word shows them in the same positions from the next cycle, with done low.
- R2: An accepted step with inner remaining above 1 lowers inner remaining by one and leaves the other fields unchanged.
- R3: An accepted step with inner remaining equal to 1 and outer remaining above 1 sets inner remaining to the inner start value and lowers outer remaining by one.
- R4: An inner field value of 0x00 counts as 256, and an outer field value of 0x0000 counts as 65536. Such runs take 256 inner steps per outer pass, and 65536 outer passes, respectively.
- R5: The step taken with inner and outer remaining both equal to 1 raises the last output in that same cycle. Without reload, the output word afterwards holds 0x0001 in bits 31:16, 0x01 in bits 15:8 and an unchanged start field, and done is high.
- R6: With reload enabled at load time, the output word after the final step equals the reload word captured at load.
- R7: An error strobe while running ends the run with the output word unchanged from before that cycle's step. It raises done and the aborted flag.
- R8: At load, if the decoded inner remaining value exceeds the decoded inner start value, the open-error flag is raised and held until the next load. No steps are counted in that case.
- R9: Step and error strobes while idle, done or refused leave the output word and all flags unchanged.
- R10: A load in the same cycle as a step or an error is taken as a load only.
- R11: Synchronous reset clears the output word and all flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| load_i | input | 1 | Load counter word and reload settings |
| desc_word_i | input | 32 | Counter word to load |
| reload_en_i | input | 1 | Enable reload after the final transfer (captured at load) |
| reload_word_i | input | 32 | Reload word (captured at load) |
| step_i | input | 1 | One transfer completed |
| err_i | input | 1 | The current transfer failed |
| desc_word_o | output | 32 | Counter word for write-back |
| last_o | output | 1 | The step in this cycle is the final transfer |
| done_o | output | 1 | Sequence ended; write-back word is valid |
| aborted_o | output | 1 | Sequence ended by an error |
| open_err_o | output | 1 | Loaded descriptor was inconsistent |

## Verification
The counter is exercised with a short 4x3 run, a run whose final step triggers reload, a run cut off by an error in mid-count, and full-size runs with a zero inner field and a zero outer field. The short run separates the plain inner decrement from the wrap into the outer loop. The zero-field runs show whether each field's maximum encoding is decoded rather than treated as an empty count. Refused descriptors use the edge pair 0x00 against 0xFF, which catches a raw byte comparison. Strobes sent after done, after an abort and on a refused descriptor, together with a load that collides with a step, confirm that nothing moves when it should not.

// File: rtl/nxc_pkg.sv
package nxc_pkg;

    typedef enum logic [2:0] {
        NXC_IDLE  = 3'd0,
        NXC_RUN   = 3'd1,
        NXC_DONE  = 3'd2,
        NXC_ABORT = 3'd3,
        NXC_BAD   = 3'd4
    } nxc_state_e;

endpackage

// File: rtl/nxc_decode.sv
module nxc_decode #(
    parameter int W = 8
) (
    input  logic [W-1:0] raw_i,
    output logic [W:0]   val_o
);
    always_comb begin
        if (raw_i == '0) val_o = {1'b1, {W{1'b0}}};
        else             val_o = {1'b0, raw_i};
    end
endmodule

// File: rtl/nxc_step.sv
module nxc_step #(
    parameter int IW = 8,
    parameter int OW = 16
) (
    input  logic [IW-1:0] iin_i,
    input  logic [IW-1:0] irm_i,
    input  logic [OW-1:0] orm_i,
    output logic [IW-1:0] irm_nx_o,
    output logic [OW-1:0] orm_nx_o,
    output logic          fin_o
);
    logic inner_end;

    always_comb begin
        inner_end = (irm_i == IW'(1));
        fin_o     = inner_end && (orm_i == OW'(1));
        if (inner_end) begin
            irm_nx_o = iin_i;
            orm_nx_o = orm_i - OW'(1);
        end else begin
            irm_nx_o = irm_i - IW'(1);
            orm_nx_o = orm_i;
        end
    end
endmodule

// File: rtl/nested_xfer_counter.sv
module nested_xfer_counter
    import nxc_pkg::*;
#(
    parameter int INNER_W = 8,
    parameter int OUTER_W = 16
) (
    input  logic                           clk,
    input  logic                           rst,
    input  logic                           load_i,
    input  logic [OUTER_W+2*INNER_W-1:0]   desc_word_i,
    input  logic                           reload_en_i,
    input  logic [OUTER_W+2*INNER_W-1:0]   reload_word_i,
    input  logic                           step_i,
    input  logic                           err_i,
    output logic [OUTER_W+2*INNER_W-1:0]   desc_word_o,
    output logic                           last_o,
    output logic                           done_o,
    output logic                           aborted_o,
    output logic                           open_err_o
);
    localparam int WORD_W = OUTER_W + 2 * INNER_W;
    localparam int IRM_LO = INNER_W;
    localparam int ORM_LO = 2 * INNER_W;

    typedef struct packed {
        nxc_state_e          state;
        logic [INNER_W-1:0]  iin;
        logic [INNER_W-1:0]  irm;
        logic [OUTER_W-1:0]  orm;
        logic                reload_en;
        logic [WORD_W-1:0]   reload_word;
    } cnt_st_t;

    cnt_st_t st_d, st_q;

    // field views of the incoming word
    logic [INNER_W-1:0] ld_iin, ld_irm;
    logic [OUTER_W-1:0] ld_orm;
    assign ld_iin = desc_word_i[INNER_W-1:0];
    assign ld_irm = desc_word_i[ORM_LO-1:IRM_LO];
    assign ld_orm = desc_word_i[WORD_W-1:ORM_LO];

    // consistency check on decoded values
    logic [INNER_W:0] ld_iin_val, ld_irm_val;
    nxc_decode #(.W(INNER_W)) u_dec_iin (.raw_i(ld_iin), .val_o(ld_iin_val));
    nxc_decode #(.W(INNER_W)) u_dec_irm (.raw_i(ld_irm), .val_o(ld_irm_val));
    logic ld_bad;
    assign ld_bad = ld_irm_val > ld_iin_val;

    // count arithmetic
    logic [INNER_W-1:0] irm_nx;
    logic [OUTER_W-1:0] orm_nx;
    logic               fin;
    nxc_step #(.IW(INNER_W), .OW(OUTER_W)) u_step (
        .iin_i    (st_q.iin),
        .irm_i    (st_q.irm),
        .orm_i    (st_q.orm),
        .irm_nx_o (irm_nx),
        .orm_nx_o (orm_nx),
        .fin_o    (fin)
    );

    logic running, take_step;
    assign running   = (st_q.state == NXC_RUN);
    assign take_step = running && step_i && !err_i && !load_i;

    always_comb begin
        st_d = st_q;
        if (load_i) begin
            st_d.iin         = ld_iin;
            st_d.irm         = ld_irm;
            st_d.orm         = ld_orm;
            st_d.reload_en   = reload_en_i;
            st_d.reload_word = reload_word_i;
            st_d.state       = ld_bad ? NXC_BAD : NXC_RUN;
        end else if (running && err_i) begin
            st_d.state = NXC_ABORT;
        end else if (take_step) begin
            if (fin) begin
                st_d.state = NXC_DONE;
                if (st_q.reload_en) begin
                    st_d.iin = st_q.reload_word[INNER_W-1:0];
                    st_d.irm = st_q.reload_word[ORM_LO-1:IRM_LO];
                    st_d.orm = st_q.reload_word[WORD_W-1:ORM_LO];
                end
            end else begin
                st_d.irm = irm_nx;
                st_d.orm = orm_nx;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign desc_word_o = {st_q.orm, st_q.irm, st_q.iin};
    assign last_o      = take_step && fin;
    assign done_o      = (st_q.state == NXC_DONE) || (st_q.state == NXC_ABORT);
    assign aborted_o   = (st_q.state == NXC_ABORT);
    assign open_err_o  = (st_q.state == NXC_BAD);

    // R5: final step leads to done
    a_r5_last_sets_done: assert property (@(posedge clk) disable iff (rst)
        last_o |=> done_o && !aborted_o);
    // R9: done state frozen until a load
    a_r9_done_frozen: assert property (@(posedge clk) disable iff (rst)
        (done_o && !load_i) |=> done_o && $stable(desc_word_o));
    // R7: error freezes the word
    a_r7_err_freeze: assert property (@(posedge clk) disable iff (rst)
        (running && err_i && !load_i) |=> aborted_o && $stable(desc_word_o));
    // R10: load wins and shows the loaded word
    a_r10_load_wins: assert property (@(posedge clk) disable iff (rst)
        load_i |=> !done_o && desc_word_o == $past(desc_word_i));
    // R8: refused descriptor never counts
    a_r8_no_count: assert property (@(posedge clk) disable iff (rst)
        open_err_o |-> !last_o);
    // R3: inner wrap restores start value
    a_r3_wrap: assert property (@(posedge clk) disable iff (rst)
        (take_step && st_q.irm == INNER_W'(1) && st_q.orm != OUTER_W'(1))
        |=> st_q.irm == $past(st_q.iin) && st_q.orm == $past(st_q.orm) - OUTER_W'(1));
    // R2: plain inner decrement
    a_r2_dec: assert property (@(posedge clk) disable iff (rst)
        (take_step && st_q.irm != INNER_W'(1))
        |=> st_q.irm == $past(st_q.irm) - INNER_W'(1) && $stable(st_q.orm));
endmodule

// File: tb/nested_xfer_counter_tb_top.sv
module nested_xfer_counter_tb_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        load_i = 1'b0, reload_en_i = 1'b0, step_i = 1'b0, err_i = 1'b0;
    logic [31:0] desc_word_i = '0, reload_word_i = '0;
    logic [31:0] desc_word_o;
    logic        last_o, done_o, aborted_o, open_err_o;

    always #4 clk = ~clk;

    nested_xfer_counter dut_i (
        .clk(clk), .rst(rst), .load_i(load_i), .desc_word_i(desc_word_i),
        .reload_en_i(reload_en_i), .reload_word_i(reload_word_i),
        .step_i(step_i), .err_i(err_i), .desc_word_o(desc_word_o),
        .last_o(last_o), .done_o(done_o), .aborted_o(aborted_o),
        .open_err_o(open_err_o)
    );

    typedef struct {
        logic [31:0] word;
        logic        done, abrt, bad;
        string       req;
    } exp_t;

    exp_t exp_q[$];
    int   n_chk = 0, n_bad = 0;

    // reference model state
    logic [7:0]  m_iin = 0, m_irm = 0;
    logic [15:0] m_orm = 0;
    logic        m_run = 0, m_done = 0, m_abrt = 0, m_bad = 0, m_ren = 0;
    logic [31:0] m_rw = 0;

    function automatic int dec8(logic [7:0] v);
        return (v == 0) ? 256 : int'(v);
    endfunction

    task automatic check(string req, string what, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // monitor
    always @(negedge clk) begin
        while (exp_q.size() > 0) begin
            exp_t e;
            e = exp_q.pop_front();
            check(e.req, "word",     desc_word_o, e.word);
            check(e.req, "done",     {31'b0, done_o}, {31'b0, e.done});
            check(e.req, "aborted",  {31'b0, aborted_o}, {31'b0, e.abrt});
            check(e.req, "open_err", {31'b0, open_err_o}, {31'b0, e.bad});
        end
    end

    task automatic push(string req);
        exp_t e;
        e.word = {m_orm, m_irm, m_iin};
        e.done = m_done; e.abrt = m_abrt; e.bad = m_bad; e.req = req;
        exp_q.push_back(e);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; load_i = 0; step_i = 0; err_i = 0;
        @(posedge clk);
        m_iin = 0; m_irm = 0; m_orm = 0; m_run = 0; m_done = 0;
        m_abrt = 0; m_bad = 0; m_ren = 0; m_rw = 0;
        push("R11");
        @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic op(string req, logic ld, logic [31:0] w, logic ren,
                      logic [31:0] rw, logic st, logic er);
        logic exp_last;
        @(negedge clk);
        load_i = ld; desc_word_i = w; reload_en_i = ren; reload_word_i = rw;
        step_i = st; err_i = er;
        exp_last = !ld && m_run && st && !er && m_irm == 8'd1 && m_orm == 16'd1;
        #1;
        check(exp_last ? "R5" : req, "last", {31'b0, last_o}, {31'b0, exp_last});
        if (ld) begin
            m_iin = w[7:0]; m_irm = w[15:8]; m_orm = w[31:16];
            m_ren = ren; m_rw = rw; m_done = 0; m_abrt = 0;
            m_bad = dec8(m_irm) > dec8(m_iin);
            m_run = !m_bad;
        end else if (m_run && er) begin
            m_run = 0; m_done = 1; m_abrt = 1;
        end else if (m_run && st) begin
            if (m_irm == 1 && m_orm == 1) begin
                m_run = 0; m_done = 1;
                if (m_ren) begin
                    m_iin = m_rw[7:0]; m_irm = m_rw[15:8]; m_orm = m_rw[31:16];
                end
            end else if (m_irm == 1) begin
                m_irm = m_iin; m_orm = m_orm - 16'd1;
            end else begin
                m_irm = m_irm - 8'd1;
            end
        end
        @(posedge clk);
        push(req);
    endtask

    task automatic load(string req, logic [31:0] w, logic ren, logic [31:0] rw);
        op(req, 1'b1, w, ren, rw, 1'b0, 1'b0);
    endtask

    task automatic steps(string req, int n);
        for (int i = 0; i < n; i++) op(req, 1'b0, '0, 1'b0, '0, 1'b1, 1'b0);
    endtask

    initial begin
        #(8 * 200000);
        n_chk++; n_bad++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        do_reset();                                   // R11 reset state
        // R1 load, R2/R3 counting, R5 final
        load("R1", 32'h0003_0404, 1'b0, '0);
        steps("R2", 3);                                // 4 -> 1
        steps("R3", 1);                                // wrap, orm 3->2
        steps("R2", 3);
        steps("R3", 1);                                // orm 2->1
        steps("R2", 3);
        steps("R5", 1);                                // final step
        steps("R9", 3);                                // ignored while done
        op("R9", 1'b0, '0, 1'b0, '0, 1'b0, 1'b1);      // error ignored while done
        // R6 reload
        load("R6", 32'h0001_0202, 1'b1, 32'h0005_0707);
        steps("R6", 2);
        steps("R9", 2);
        // R7 error mid-run
        load("R7", 32'h0002_0303, 1'b0, '0);
        steps("R7", 1);
        op("R7", 1'b0, '0, 1'b0, '0, 1'b1, 1'b1);
        steps("R9", 2);
        // R8 open error
        load("R8", 32'h0001_0503, 1'b0, '0);
        steps("R8", 2);
        load("R8", 32'h0001_00FF, 1'b0, '0);           // 256 > 255
        steps("R9", 1);
        // R10 load collides with step/error
        load("R10", 32'h0002_0606, 1'b0, '0);
        steps("R2", 2);
        op("R10", 1'b1, 32'h0004_0909, 1'b0, '0, 1'b1, 1'b0);
        op("R10", 1'b1, 32'h0001_0202, 1'b0, '0, 1'b0, 1'b1);
        steps("R2", 1);
        steps("R5", 1);
        // R4 inner 0 means 256 (not an open error)
        load("R4", 32'h0002_0000, 1'b0, '0);
        steps("R4", 511);
        steps("R5", 1);
        // R4 outer 0 means 65536
        load("R4", 32'h0000_0101, 1'b0, '0);
        steps("R4", 65535);
        steps("R5", 1);
        // R11 mid-run reset
        load("R11", 32'h0003_0505, 1'b0, '0);
        steps("R2", 2);
        do_reset();
        steps("R9", 1);
        @(negedge clk);
        @(negedge clk);
        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule